// File: doc/BRIEF.md
# Motor PWM Control and Status Register

This block is the control and status register for a multi-channel motor-control PWM unit. Software reaches it through a small register bus. One address holds an 8-bit control word: a global enable, a load-OK bit, a two-bit current-sense correction select, a reload flag, an interrupt enable and two bank software-disable bits. A second address holds a disable mapping byte that can be written only once after reset. The mapping byte chooses which pins each bank-disable bit forces inactive.

The PWM counter drives two inputs. One pulse marks the start of each reload cycle and the other marks the start of each PWM cycle. A reload pulse always sets the reload flag. Software clears the flag with a two-step handshake: it reads the control word while the flag is set, then writes a zero to the flag bit. A reload between those two steps voids the handshake. The interrupt request is raised while the flag is set and the interrupt enable is 1.

A bank disable takes effect as soon as the bit is written. Its release waits for the next PWM cycle start, so a pin is never re-enabled in the middle of a cycle.

Top module: `pwm_ctl_reg`

## Requirements
- R1: After reset, the control word and the mapping byte read 0x00, `irq` is 0 and `force_off` is 0.
- R2: Bus address 0 selects the control word and bus address 1 selects the mapping byte. `bus_rdata` shows the selected register combinationally. The control word bits are: bit 7 bank-X disable, bit 6 bank-Y disable, bit 5 interrupt enable, bit 4 reload flag, bits 3:2 correction select, bit 1 load-OK, bit 0 PWM enable. A write to address 0 stores every bit except bit 4. Bits 1:0 and 3:2 appear on `pwm_enable`, `load_ok` and `corr_sel`.
- R3: A `reload_pulse` sets the reload flag in the next cycle, whatever the value of load-OK.
- R4: A read strobe to address 0 while the flag is 1 arms the clear. A following write to address 0 with bit 4 at 0 then clears the flag.
- R5: Writing 1 to bit 4 never changes the flag. A zero write that is not preceded by an arming read also leaves the flag unchanged. Any write to address 0 disarms the clear.
- R6: A reload pulse disarms the clear, so a zero write after it leaves the flag set. When a reload pulse and the completing zero write fall in the same cycle, the flag stays set.
- R7: `irq` is 1 exactly when the reload flag and the interrupt enable are both 1. Clearing either bit drops the request.
- R8: In the cycle after a write that sets a bank-disable bit, the `force_off` bits of that bank follow the mapping byte.
- R9: After a bank-disable bit is written to 0, that bank's `force_off` bits stay as they were until a `cycle_start` pulse. They clear in the cycle after that pulse.
- R10: The first write to address 1 after reset stores the mapping byte. Every later write to address 1 is ignored, and the stored byte reads back at address 1.
- R11: Mapping byte bits 3:0 select `force_off[3:0]`, which belong to bank X. Bits 7:4 select `force_off[7:4]`, which belong to bank Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = control word, 1 = mapping byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| reload_pulse | input | 1 | Start of a reload cycle |
| cycle_start | input | 1 | Start of a PWM cycle |
| pwm_enable | output | 1 | Global PWM enable |
| load_ok | output | 1 | Load-OK bit |
| corr_sel | output | 2 | Current-sense correction select |
| irq | output | 1 | Reload interrupt request |
| force_off | output | 8 | Per-pin force-inactive mask (bank X low, bank Y high) |

## Verification
The bench goes after the corners of the flag handshake. These are a zero write with no arming read, a reload between the read and the write, and a reload in the same cycle as the completing write. A design that clears on any zero write, or lets the write beat the reload, would lose a reload event and drop its interrupt. The bench also writes a bank-disable bit to 0 between cycle starts. A design that released at once would re-enable pins in the middle of a cycle. Finally, it rewrites the mapping byte; a design that does not lock it would change the pin masks after start-up.

// File: rtl/pwm_ctl_reg.sv
module pwm_ctl_reg #(
  parameter int PINS_PER_BANK = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic                       reload_pulse,
  input  logic                       cycle_start,
  output logic                       pwm_enable,
  output logic                       load_ok,
  output logic [1:0]                 corr_sel,
  output logic                       irq,
  output logic [2*PINS_PER_BANK-1:0] force_off
);
  localparam int MAPW = 2 * PINS_PER_BANK;

  logic            dis_x_q, dis_y_q, ie_q, flag_q, ldok_q, en_q;
  logic [1:0]      corr_q;
  logic            arm_q, held_x_q, held_y_q, locked_q;
  logic [MAPW-1:0] map_q;
  logic            wr_ctl, rd_ctl, wr_map, eff_x, eff_y;

  assign wr_ctl = bus_wr && !bus_addr;
  assign rd_ctl = bus_rd && !bus_addr;
  assign wr_map = bus_wr && bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_x_q  <= 1'b0;
      dis_y_q  <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      corr_q   <= 2'b00;
      ldok_q   <= 1'b0;
      en_q     <= 1'b0;
      arm_q    <= 1'b0;
      held_x_q <= 1'b0;
      held_y_q <= 1'b0;
      map_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        dis_x_q <= bus_wdata[7];
        dis_y_q <= bus_wdata[6];
        ie_q    <= bus_wdata[5];
        corr_q  <= bus_wdata[3:2];
        ldok_q  <= bus_wdata[1];
        en_q    <= bus_wdata[0];
      end
      if (reload_pulse)
        flag_q <= 1'b1;
      else if (wr_ctl && !bus_wdata[4] && arm_q)
        flag_q <= 1'b0;
      if (reload_pulse || wr_ctl)
        arm_q <= 1'b0;
      else if (rd_ctl && flag_q)
        arm_q <= 1'b1;
      held_x_q <= cycle_start ? dis_x_q : (held_x_q | dis_x_q);
      held_y_q <= cycle_start ? dis_y_q : (held_y_q | dis_y_q);
      if (wr_map && !locked_q) begin
        map_q    <= bus_wdata[MAPW-1:0];
        locked_q <= 1'b1;
      end
    end
  end

  assign eff_x      = dis_x_q | held_x_q;
  assign eff_y      = dis_y_q | held_y_q;
  assign force_off  = {map_q[MAPW-1:PINS_PER_BANK] & {PINS_PER_BANK{eff_y}},
                       map_q[PINS_PER_BANK-1:0]    & {PINS_PER_BANK{eff_x}}};
  assign irq        = flag_q & ie_q;
  assign pwm_enable = en_q;
  assign load_ok    = ldok_q;
  assign corr_sel   = corr_q;
  assign bus_rdata  = bus_addr ? 8'(map_q)
                               : {dis_x_q, dis_y_q, ie_q, flag_q, corr_q, ldok_q, en_q};
endmodule

module pwm_ctl_reg_chk #(
  parameter int PINS_PER_BANK = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_addr,
  input logic                       bus_wr,
  input logic [7:0]                 bus_wdata,
  input logic                       reload_pulse,
  input logic                       cycle_start,
  input logic                       irq,
  input logic [2*PINS_PER_BANK-1:0] force_off,
  input logic                       flag,
  input logic                       ie,
  input logic [2*PINS_PER_BANK-1:0] map,
  input logic                       locked,
  input logic                       eff_x
);
  a_r3_reload_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> flag);
  a_r6_reload_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pulse && bus_wr && !bus_addr && !bus_wdata[4]) |=> flag);
  a_r4_flag_falls_on_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(bus_wr && !bus_addr && !bus_wdata[4] && !reload_pulse));
  a_r7_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
  a_r8_disable_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_wdata[7]) |=> (force_off[PINS_PER_BANK-1:0] == map[PINS_PER_BANK-1:0]));
  a_r9_release_at_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eff_x) |-> $past(cycle_start));
  a_r10_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(map));
endmodule

bind pwm_ctl_reg pwm_ctl_reg_chk #(.PINS_PER_BANK(PINS_PER_BANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .reload_pulse(reload_pulse), .cycle_start(cycle_start),
  .irq(irq), .force_off(force_off), .flag(flag_q), .ie(ie_q), .map(map_q),
  .locked(locked_q), .eff_x(eff_x)
);

// File: tb/pwm_ctl_reg_bench.sv
module pwm_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       reload_pulse = 1'b0, cycle_start = 1'b0;
  logic [7:0] bus_rdata, force_off;
  logic       pwm_enable, load_ok, irq;
  logic [1:0] corr_sel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_ctl_reg u_pwm_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reload_pulse(reload_pulse),
    .cycle_start(cycle_start), .pwm_enable(pwm_enable), .load_ok(load_ok),
    .corr_sel(corr_sel), .irq(irq), .force_off(force_off)
  );

  // Behavioural reference model
  logic [7:0] m_ctl = 8'h00, m_map = 8'h00;
  bit m_armed = 0, m_lock = 0, m_hold_x = 0, m_hold_y = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 8'h00; m_map = 8'h00; m_armed = 0; m_lock = 0; m_hold_x = 0; m_hold_y = 0;
    end else begin
      bit flag_next;
      bit old_x, old_y;
      old_x = m_ctl[7]; old_y = m_ctl[6];
      flag_next = m_ctl[4];
      if (reload_pulse) flag_next = 1;
      else if (bus_wr && !bus_addr && !bus_wdata[4] && m_armed) flag_next = 0;
      if (reload_pulse || (bus_wr && !bus_addr)) m_armed = 0;
      else if (bus_rd && !bus_addr && m_ctl[4]) m_armed = 1;
      if (bus_wr && !bus_addr) m_ctl = bus_wdata;
      m_ctl[4] = flag_next;
      if (cycle_start) begin m_hold_x = old_x; m_hold_y = old_y; end
      else begin m_hold_x = m_hold_x || old_x; m_hold_y = m_hold_y || old_y; end
      if (bus_wr && bus_addr && !m_lock) begin m_map = bus_wdata; m_lock = 1; end
    end
  end

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] exp_force;
      exp_force[3:0] = m_map[3:0] & {4{m_ctl[7] | m_hold_x}};
      exp_force[7:4] = m_map[7:4] & {4{m_ctl[6] | m_hold_y}};
      check("R2", "rdata vs model", bus_rdata, bus_addr ? m_map : m_ctl);
      check("R7", "irq vs model", {7'd0, irq}, {7'd0, m_ctl[4] & m_ctl[5]});
      check("R9", "force_off vs model", force_off, exp_force);
      check("R2", "side outputs", {4'd0, corr_sel, load_ok, pwm_enable}, {4'd0, m_ctl[3:0]});
    end
  end

  task automatic op(input logic a, input logic w, input logic r, input logic [7:0] d,
                    input logic rl, input logic cs);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; reload_pulse = rl; cycle_start = cs;
    @(negedge clk);
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; reload_pulse = 0; cycle_start = 0;
  endtask

  task automatic peek(input logic a, input string req, input logic [7:0] exp);
    bus_addr = a; #0.1;
    check(req, a ? "map readback" : "ctl readback", bus_rdata, exp);
    bus_addr = 0; #0.1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(0, "R1", 8'h00);
    peek(1, "R1", 8'h00);
    check("R1", "irq", {7'd0, irq}, 8'h00);
    check("R1", "force_off", force_off, 8'h00);
    // R2 field store
    op(0, 1, 0, 8'h2F, 0, 0);
    peek(0, "R2", 8'h2F);
    check("R2", "corr_sel/load_ok/enable", {4'd0, corr_sel, load_ok, pwm_enable}, 8'h0F);
    // R5 writing 1 to flag has no effect
    op(0, 1, 0, 8'h3F, 0, 0);
    peek(0, "R5", 8'h2F);
    // R3 reload sets flag, R7 irq
    op(0, 0, 0, 8'h00, 1, 0);
    peek(0, "R3", 8'h3F);
    check("R7", "irq pending", {7'd0, irq}, 8'h01);
    // R5 unarmed zero write
    op(0, 1, 0, 8'h2F, 0, 0);
    peek(0, "R5", 8'h3F);
    // R4 read then zero write
    op(0, 0, 1, 8'h00, 0, 0);
    op(0, 1, 0, 8'h2F, 0, 0);
    peek(0, "R4", 8'h2F);
    check("R7", "irq after clear", {7'd0, irq}, 8'h00);
    // R6 reload between read and write
    op(0, 0, 0, 8'h00, 1, 0);
    op(0, 0, 1, 8'h00, 0, 0);
    op(0, 0, 0, 8'h00, 1, 0);
    op(0, 1, 0, 8'h2F, 0, 0);
    peek(0, "R6", 8'h3F);
    // R6 reload same cycle as completing write
    op(0, 0, 1, 8'h00, 0, 0);
    op(0, 1, 0, 8'h2F, 1, 0);
    peek(0, "R6", 8'h3F);
    // R5 write disarms: read, write 1 to flag, then zero write
    op(0, 0, 1, 8'h00, 0, 0);
    op(0, 1, 0, 8'h3F, 0, 0);
    op(0, 1, 0, 8'h2F, 0, 0);
    peek(0, "R5", 8'h3F);
    // R7 enable off drops irq
    op(0, 1, 0, 8'h0D, 0, 0);
    check("R7", "irq inhibited", {7'd0, irq}, 8'h00);
    // R3 reload with load-OK at 0
    op(0, 0, 1, 8'h00, 0, 0);
    op(0, 1, 0, 8'h0C, 0, 0);
    peek(0, "R4", 8'h0C);
    op(0, 0, 0, 8'h00, 1, 0);
    peek(0, "R3", 8'h1C);
    op(0, 0, 1, 8'h00, 0, 0);
    op(0, 1, 0, 8'h00, 0, 0);
    peek(0, "R4", 8'h00);
    // R10 write-once map
    op(1, 1, 0, 8'hA5, 0, 0);
    peek(1, "R10", 8'hA5);
    op(1, 1, 0, 8'hFF, 0, 0);
    peek(1, "R10", 8'hA5);
    // R8 / R11 disables
    op(0, 1, 0, 8'h80, 0, 0);
    check("R8", "bank X forced", force_off, 8'h05);
    op(0, 1, 0, 8'hC0, 0, 0);
    check("R11", "both banks forced", force_off, 8'hA5);
    // R9 release waits for cycle start
    op(0, 1, 0, 8'h40, 0, 0);
    check("R9", "X held before cycle start", force_off, 8'hA5);
    op(0, 0, 0, 8'h00, 0, 1);
    check("R9", "X released at cycle start", force_off, 8'hA0);
    op(0, 1, 0, 8'h00, 0, 0);
    repeat (3) @(negedge clk);
    check("R9", "Y still held", force_off, 8'hA0);
    op(0, 0, 0, 8'h00, 0, 1);
    check("R9", "Y released", force_off, 8'h00);
    // R9 cycle start while bit still 1 keeps force
    op(0, 1, 0, 8'h40, 0, 0);
    op(0, 0, 0, 8'h00, 0, 1);
    check("R11", "Y alone forced", force_off, 8'hA0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule